// File: doc/BRIEF.md
# Weighted Table-Driven Virtual Channel Allocator

This block belongs to the allocation stage of an ingress-buffered wormhole router. Each ingress virtual channel whose head packet has finished route computation raises a request. The request carries four identifiers: the node the packet came from, its flow number, the next-hop node and the flow number it will use at that node. Together these four fields address a programmable weight table. Each table entry gives one small weight per output virtual channel, and a weight of zero means that channel is not a candidate. Fully dynamic allocation is programmed by giving every channel the same weight. Static set allocation is programmed by giving a single channel a nonzero weight.

In every cycle the block examines the pending requests one after another. The examination starts at a requester chosen from a per-router 32-bit LFSR, so the order rotates pseudorandomly from cycle to cycle. Each request draws one output channel at random from the candidates that are still free, with probability in proportion to the weights. A channel taken by an earlier request in the same cycle is removed from the candidates of the later ones. A grant is given combinationally in the cycle of the request. The granted channel then belongs to that packet until a tail-departure pulse arrives for the channel.

Each output channel has a two-state controller with the states FREE and HELD. The CLAIM transition (FREE to HELD) fires on a grant. The DRAIN transition (HELD to FREE) fires on the tail pulse for that channel. The LFSR seed can be loaded so that runs can be reproduced.

Top module: `vca_weighted_alloc`

## Requirements
- R1: After reset every output channel is FREE and every table entry holds only zero weights, so no request is granted until an entry has been written.
- R2: A request is granted only a channel whose weight is nonzero in the entry addressed by {prev, flow, next, nflow}, most significant field first. The weight of channel v sits at bits [3v+2:3v] of the entry. A request whose entry is all zero is never granted.
- R3: Only a FREE channel is granted. A request with no free candidate gets no grant and is retried in every later cycle. If any pending request has a free candidate, at least one grant is given in that cycle.
- R4: An entry with exactly one nonzero weight always yields that channel when the channel is free.
- R5: In one cycle each channel is granted to at most one requester, each requester receives at most one channel, and a grant appears only where req_valid is high.
- R6: A tail pulse on a HELD channel makes it grantable from the next cycle, not in the cycle of the pulse. A tail pulse on a FREE channel is ignored, also when a claim of that channel falls in the same cycle; the channel then becomes HELD.
- R7: Among free candidates the choice follows the weights: with weights 3 and 1, the heavier channel wins about three quarters of the draws. With equal weights every channel is chosen.
- R8: When two requesters compete for the only free channel, the randomized examination order lets each of them win a substantial share of the cycles.
- R9: A seed load sets the LFSR in the next cycle, and a zero seed is replaced by 1. Loading the same seed and repeating the same stimulus reproduces the same grants, and a zero seed behaves exactly like a seed of 1.
- R10: A table write takes effect for requests from the next cycle on. A request in the same cycle as the write uses the old contents.
- R11: The grant and the granted channel index appear in the same cycle as the request, and the channel becomes HELD at the following clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| seed_load | input | 1 | Load the LFSR from seed_val |
| seed_val | input | LFSR_W | Seed value (zero is replaced by 1) |
| tbl_we | input | 1 | Table write strobe |
| tbl_prev | input | NODE_W | Write key: previous node |
| tbl_flow | input | FLOW_W | Write key: flow |
| tbl_next | input | NODE_W | Write key: next node |
| tbl_nflow | input | FLOW_W | Write key: next flow |
| tbl_wts | input | NUM_VC*WGT_W | Weights to write, channel v at [v*WGT_W +: WGT_W] |
| req_valid | input | NUM_REQ | Pending allocation request per ingress channel |
| req_prev | input | NUM_REQ*NODE_W | Previous node per requester |
| req_flow | input | NUM_REQ*FLOW_W | Flow per requester |
| req_next | input | NUM_REQ*NODE_W | Next node per requester |
| req_nflow | input | NUM_REQ*FLOW_W | Next flow per requester |
| tail_done | input | NUM_VC | Tail-flit departure pulse per output channel |
| gnt | output | NUM_REQ | Grant per requester, same cycle |
| gnt_vc | output | NUM_REQ*VC_IDX_W | Granted channel index per requester |

## Verification
A release and a new claim of the same output channel can fall in the same cycle. The bench keeps a request pending on a held channel and pulses that channel's tail. It then expects no grant in the pulse cycle and the grant one cycle later. The bench also pulses the tail of a free channel in the very cycle that channel is claimed, and then shows through a second request that the channel stayed HELD. In the random phase, tail pulses and fresh requests overlap freely, and every grant is judged against a reference ownership model kept in the bench.

// File: rtl/vca_pkg.sv
package vca_pkg;

    typedef enum logic {
        SLOT_FREE = 1'b0,
        SLOT_HELD = 1'b1
    } slot_state_e;

endpackage

// File: rtl/vca_lfsr.sv
module vca_lfsr #(
    parameter int                LFSR_W  = 32,
    parameter logic [LFSR_W-1:0] TAPS    = 32'h8020_0003,
    parameter logic [LFSR_W-1:0] RST_VAL = 32'hACE1_2468
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [LFSR_W-1:0] seed,
    output logic [LFSR_W-1:0] state
);

    logic [LFSR_W-1:0] state_d;

    always_comb begin
        if (load) begin
            state_d = (seed == '0) ? LFSR_W'(1) : seed;
        end else begin
            state_d = state >> 1;
            if (state[0]) state_d = state_d ^ TAPS;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= RST_VAL;
        else        state <= state_d;
    end

endmodule

// File: rtl/vca_wtable.sv
module vca_wtable #(
    parameter int KEY_W   = 8,
    parameter int ENT_W   = 12,
    parameter int NUM_RD  = 4,
    localparam int DEPTH  = 1 << KEY_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [KEY_W-1:0]        wr_key,
    input  logic [ENT_W-1:0]        wr_data,
    input  logic [NUM_RD*KEY_W-1:0] rd_key,
    output logic [NUM_RD*ENT_W-1:0] rd_data
);

    logic [ENT_W-1:0] mem [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int e = 0; e < DEPTH; e++) mem[e] <= '0;
        end else if (wr_en) begin
            mem[wr_key] <= wr_data;
        end
    end

    always_comb begin
        for (int i = 0; i < NUM_RD; i++)
            rd_data[i*ENT_W +: ENT_W] = mem[rd_key[i*KEY_W +: KEY_W]];
    end

endmodule

// File: rtl/vca_vc_slot.sv
module vca_vc_slot
    import vca_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic claim,
    input  logic drain,
    output logic held
);

    slot_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SLOT_FREE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SLOT_FREE: if (claim) state_d = SLOT_HELD;   // CLAIM
            SLOT_HELD: if (drain) state_d = SLOT_FREE;   // DRAIN
        endcase
    end

    always_comb held = (state_q == SLOT_HELD);

endmodule

// File: rtl/vca_pick.sv
module vca_pick #(
    parameter int NUM_VC  = 4,
    parameter int WGT_W   = 3,
    parameter int DRAW_W  = 6,
    localparam int VC_IDX_W = $clog2(NUM_VC),
    localparam int TOT_W    = WGT_W + $clog2(NUM_VC) + 1
) (
    input  logic                    active,
    input  logic [NUM_VC*WGT_W-1:0] wts,
    input  logic [NUM_VC-1:0]       avail_in,
    input  logic [DRAW_W-1:0]       draw,
    output logic                    hit,
    output logic [VC_IDX_W-1:0]     vc,
    output logic [NUM_VC-1:0]       avail_out
);

    logic [NUM_VC-1:0]       cand;
    logic [TOT_W-1:0]        total;
    logic [TOT_W-1:0]        cum;
    logic [TOT_W-1:0]        target;
    logic [DRAW_W+TOT_W-1:0] scaled;

    always_comb begin
        total = '0;
        for (int v = 0; v < NUM_VC; v++) begin
            cand[v] = active && avail_in[v] && (wts[v*WGT_W +: WGT_W] != '0);
            if (cand[v]) total = total + TOT_W'(wts[v*WGT_W +: WGT_W]);
        end
        scaled = (DRAW_W+TOT_W)'(draw) * (DRAW_W+TOT_W)'(total);
        target = TOT_W'(scaled >> DRAW_W);
        cum = '0;
        hit = 1'b0;
        vc  = '0;
        for (int v = 0; v < NUM_VC; v++) begin
            if (cand[v]) begin
                if (!hit && (target < cum + TOT_W'(wts[v*WGT_W +: WGT_W]))) begin
                    hit = 1'b1;
                    vc  = VC_IDX_W'(v);
                end
                cum = cum + TOT_W'(wts[v*WGT_W +: WGT_W]);
            end
        end
        avail_out = avail_in;
        if (hit) avail_out[vc] = 1'b0;
    end

endmodule

// File: rtl/vca_weighted_alloc.sv
module vca_weighted_alloc #(
    parameter int NUM_REQ = 4,
    parameter int NUM_VC  = 4,
    parameter int NODE_W  = 2,
    parameter int FLOW_W  = 2,
    parameter int WGT_W   = 3,
    parameter int LFSR_W  = 32,
    parameter int DRAW_W  = 6,
    localparam int REQ_W    = $clog2(NUM_REQ),
    localparam int VC_IDX_W = $clog2(NUM_VC),
    localparam int KEY_W    = 2*NODE_W + 2*FLOW_W,
    localparam int ENT_W    = NUM_VC*WGT_W
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        seed_load,
    input  logic [LFSR_W-1:0]           seed_val,
    input  logic                        tbl_we,
    input  logic [NODE_W-1:0]           tbl_prev,
    input  logic [FLOW_W-1:0]           tbl_flow,
    input  logic [NODE_W-1:0]           tbl_next,
    input  logic [FLOW_W-1:0]           tbl_nflow,
    input  logic [ENT_W-1:0]            tbl_wts,
    input  logic [NUM_REQ-1:0]          req_valid,
    input  logic [NUM_REQ*NODE_W-1:0]   req_prev,
    input  logic [NUM_REQ*FLOW_W-1:0]   req_flow,
    input  logic [NUM_REQ*NODE_W-1:0]   req_next,
    input  logic [NUM_REQ*FLOW_W-1:0]   req_nflow,
    input  logic [NUM_VC-1:0]           tail_done,
    output logic [NUM_REQ-1:0]          gnt,
    output logic [NUM_REQ*VC_IDX_W-1:0] gnt_vc
);

    logic [LFSR_W-1:0]        lfsr_q;
    logic [NUM_REQ*KEY_W-1:0] rd_key;
    logic [NUM_REQ*ENT_W-1:0] rd_data;
    logic [NUM_VC-1:0]        vc_held;
    logic [NUM_VC-1:0]        vc_claim;
    logic [REQ_W-1:0]         rot;

    logic [REQ_W-1:0]    st_sel    [NUM_REQ];
    logic [NUM_REQ-1:0]  st_active;
    logic [ENT_W-1:0]    st_wts    [NUM_REQ];
    logic [DRAW_W-1:0]   st_draw   [NUM_REQ];
    logic [NUM_REQ-1:0]  st_hit;
    logic [VC_IDX_W-1:0] st_vc     [NUM_REQ];
    logic [NUM_VC-1:0]   st_avail  [NUM_REQ];

    vca_lfsr #(.LFSR_W(LFSR_W)) u_lfsr (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (seed_load),
        .seed  (seed_val),
        .state (lfsr_q)
    );

    always_comb begin
        for (int i = 0; i < NUM_REQ; i++)
            rd_key[i*KEY_W +: KEY_W] = {req_prev[i*NODE_W +: NODE_W],
                                        req_flow[i*FLOW_W +: FLOW_W],
                                        req_next[i*NODE_W +: NODE_W],
                                        req_nflow[i*FLOW_W +: FLOW_W]};
    end

    vca_wtable #(.KEY_W(KEY_W), .ENT_W(ENT_W), .NUM_RD(NUM_REQ)) u_tbl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (tbl_we),
        .wr_key  ({tbl_prev, tbl_flow, tbl_next, tbl_nflow}),
        .wr_data (tbl_wts),
        .rd_key  (rd_key),
        .rd_data (rd_data)
    );

    // examination order: rotation taken from the LFSR top bits
    assign rot = lfsr_q[LFSR_W-1 -: REQ_W];

    always_comb begin
        for (int p = 0; p < NUM_REQ; p++) begin
            st_sel[p]    = REQ_W'((int'(rot) + p) % NUM_REQ);
            st_active[p] = req_valid[st_sel[p]];
            st_wts[p]    = rd_data[int'(st_sel[p])*ENT_W +: ENT_W];
            for (int b = 0; b < DRAW_W; b++)
                st_draw[p][b] = lfsr_q[(p*DRAW_W + b) % LFSR_W];
        end
    end

    for (genvar p = 0; p < NUM_REQ; p++) begin : g_stage
        logic [NUM_VC-1:0] avail_in;
        if (p == 0) begin : g_first
            assign avail_in = ~vc_held;
        end else begin : g_next
            assign avail_in = st_avail[p-1];
        end
        vca_pick #(.NUM_VC(NUM_VC), .WGT_W(WGT_W), .DRAW_W(DRAW_W)) u_pick (
            .active    (st_active[p]),
            .wts       (st_wts[p]),
            .avail_in  (avail_in),
            .draw      (st_draw[p]),
            .hit       (st_hit[p]),
            .vc        (st_vc[p]),
            .avail_out (st_avail[p])
        );
    end

    assign vc_claim = ~vc_held & ~st_avail[NUM_REQ-1];

    always_comb begin
        gnt    = '0;
        gnt_vc = '0;
        for (int p = 0; p < NUM_REQ; p++) begin
            if (st_hit[p]) begin
                gnt[st_sel[p]] = 1'b1;
                gnt_vc[int'(st_sel[p])*VC_IDX_W +: VC_IDX_W] = st_vc[p];
            end
        end
    end

    for (genvar v = 0; v < NUM_VC; v++) begin : g_slot
        vca_vc_slot u_slot (
            .clk   (clk),
            .rst_n (rst_n),
            .claim (vc_claim[v]),
            .drain (tail_done[v]),
            .held  (vc_held[v])
        );
    end

endmodule

// File: rtl/vca_alloc_chk.sv
module vca_alloc_chk #(
    parameter int NUM_REQ = 4,
    parameter int NUM_VC  = 4,
    parameter int WGT_W   = 3,
    parameter int LFSR_W  = 32,
    localparam int VI     = $clog2(NUM_VC),
    localparam int ENT_W  = NUM_VC*WGT_W
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [NUM_REQ-1:0]      req_valid,
    input logic [NUM_REQ-1:0]      gnt,
    input logic [NUM_REQ*VI-1:0]   gnt_vc,
    input logic [NUM_VC-1:0]       tail_done,
    input logic [NUM_VC-1:0]       vc_held,
    input logic [NUM_VC-1:0]       vc_claim,
    input logic [NUM_REQ*ENT_W-1:0] rd_data,
    input logic                    seed_load,
    input logic [LFSR_W-1:0]       seed_val,
    input logic [LFSR_W-1:0]       lfsr_q
);

    logic [NUM_VC-1:0] seen;
    logic dup, hit_held, zero_wt;

    always_comb begin
        seen = '0;
        dup = 1'b0;
        hit_held = 1'b0;
        zero_wt = 1'b0;
        for (int i = 0; i < NUM_REQ; i++) begin
            if (gnt[i]) begin
                if (seen[gnt_vc[i*VI +: VI]]) dup = 1'b1;
                seen[gnt_vc[i*VI +: VI]] = 1'b1;
                if (vc_held[gnt_vc[i*VI +: VI]]) hit_held = 1'b1;
                if (rd_data[i*ENT_W + int'(gnt_vc[i*VI +: VI])*WGT_W +: WGT_W] == '0)
                    zero_wt = 1'b1;
            end
        end
    end

    a_r5_unique_vc: assert property (@(posedge clk) disable iff (!rst_n) !dup);
    a_r5_grant_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt & ~req_valid) == '0);
    a_r3_free_only: assert property (@(posedge clk) disable iff (!rst_n) !hit_held);
    a_r2_nonzero_weight: assert property (@(posedge clk) disable iff (!rst_n) !zero_wt);
    a_r9_seed_loaded: assert property (@(posedge clk) disable iff (!rst_n)
        seed_load |=> lfsr_q == (($past(seed_val) == '0) ? LFSR_W'(1) : $past(seed_val)));

    for (genvar v = 0; v < NUM_VC; v++) begin : g_vc
        a_r6_release: assert property (@(posedge clk) disable iff (!rst_n)
            (vc_held[v] && tail_done[v]) |=> !vc_held[v]);
        a_r6_claim_over_tail: assert property (@(posedge clk) disable iff (!rst_n)
            (vc_claim[v] && tail_done[v]) |=> vc_held[v]);
        a_r11_claim_holds: assert property (@(posedge clk) disable iff (!rst_n)
            vc_claim[v] |=> vc_held[v]);
    end

endmodule

bind vca_weighted_alloc vca_alloc_chk #(
    .NUM_REQ (NUM_REQ),
    .NUM_VC  (NUM_VC),
    .WGT_W   (WGT_W),
    .LFSR_W  (LFSR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .gnt       (gnt),
    .gnt_vc    (gnt_vc),
    .tail_done (tail_done),
    .vc_held   (vc_held),
    .vc_claim  (vc_claim),
    .rd_data   (rd_data),
    .seed_load (seed_load),
    .seed_val  (seed_val),
    .lfsr_q    (lfsr_q)
);

// File: tb/sim_vca_weighted_alloc.sv
module sim_vca_weighted_alloc;

    localparam int NREQ = 4;
    localparam int NVC  = 4;
    localparam int WW   = 3;
    localparam int LW   = 32;
    localparam int VI   = 2;
    localparam int EW   = NVC*WW;

    localparam logic [7:0] KA  = 8'b00_01_10_11; // all channels weight 1
    localparam logic [7:0] KS  = 8'b01_00_11_10; // only channel 2, weight 5
    localparam logic [7:0] KW  = 8'b10_10_01_01; // channel 0 weight 3, channel 1 weight 1
    localparam logic [7:0] KZ  = 8'b11_00_00_01; // never written
    localparam logic [7:0] KV3 = 8'b11_11_11_11; // only channel 3
    localparam logic [7:0] KS1 = 8'b00_00_01_01; // only channel 1

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic              rst_n;
    logic              seed_load;
    logic [LW-1:0]     seed_val;
    logic              tbl_we;
    logic [1:0]        tbl_prev, tbl_flow, tbl_next, tbl_nflow;
    logic [EW-1:0]     tbl_wts;
    logic [NREQ-1:0]   req_valid;
    logic [NREQ*2-1:0] req_prev, req_flow, req_next, req_nflow;
    logic [NVC-1:0]    tail_done;
    logic [NREQ-1:0]   gnt;
    logic [NREQ*VI-1:0] gnt_vc;

    vca_weighted_alloc u0 (
        .clk(clk), .rst_n(rst_n), .seed_load(seed_load), .seed_val(seed_val),
        .tbl_we(tbl_we), .tbl_prev(tbl_prev), .tbl_flow(tbl_flow),
        .tbl_next(tbl_next), .tbl_nflow(tbl_nflow), .tbl_wts(tbl_wts),
        .req_valid(req_valid), .req_prev(req_prev), .req_flow(req_flow),
        .req_next(req_next), .req_nflow(req_nflow), .tail_done(tail_done),
        .gnt(gnt), .gnt_vc(gnt_vc)
    );

    int vecs = 0;
    int errs = 0;
    bit done = 0;
    logic [EW-1:0]   bt [256];
    logic [7:0]      kq [NREQ];
    logic [NVC-1:0]  own;
    logic [NREQ-1:0] gs;
    logic [VI-1:0]   gv [NREQ];
    int seqa [24];
    int seqb [24];

    function automatic logic [WW-1:0] wt(input logic [7:0] k, input int v);
        return bt[k][v*WW +: WW];
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        vecs++;
        if (!ok) begin
            errs++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // inputs are set at a negedge; outputs are sampled 2 ns later
    task automatic run_cycle();
        bit bad2, bad3, bad5, any_ok;
        logic [NVC-1:0] seen;
        for (int i = 0; i < NREQ; i++) begin
            req_prev[i*2 +: 2]  = kq[i][7:6];
            req_flow[i*2 +: 2]  = kq[i][5:4];
            req_next[i*2 +: 2]  = kq[i][3:2];
            req_nflow[i*2 +: 2] = kq[i][1:0];
        end
        #2;
        gs = gnt;
        bad2 = 0; bad3 = 0; bad5 = 0; any_ok = 0; seen = '0;
        for (int i = 0; i < NREQ; i++) begin
            gv[i] = gnt_vc[i*VI +: VI];
            if (gs[i]) begin
                if (!req_valid[i] || seen[gv[i]]) bad5 = 1;
                seen[gv[i]] = 1'b1;
                if (own[gv[i]]) bad3 = 1;
                if (wt(kq[i], int'(gv[i])) == '0) bad2 = 1;
            end
            if (req_valid[i])
                for (int v = 0; v < NVC; v++)
                    if (!own[v] && wt(kq[i], v) != '0) any_ok = 1;
        end
        if (req_valid != '0 || gs != '0) begin
            chk(!bad2, "R2 grant of zero-weight channel", int'(bad2), 0);
            chk(!bad3, "R3 grant of held channel", int'(bad3), 0);
            chk(!(any_ok && gs == '0), "R3 work conserving", int'(gs), 1);
            chk(!bad5, "R5 grant legality", int'(gs), int'(req_valid));
        end
        for (int v = 0; v < NVC; v++) begin
            if (seen[v])           own[v] = 1'b1;
            else if (tail_done[v]) own[v] = 1'b0;
        end
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] k, input logic [EW-1:0] w);
        tbl_we = 1; tbl_prev = k[7:6]; tbl_flow = k[5:4];
        tbl_next = k[3:2]; tbl_nflow = k[1:0]; tbl_wts = w;
        run_cycle();
        tbl_we = 0;
        bt[k] = w;
    endtask

    task automatic release_all();
        tail_done = own;
        run_cycle();
        tail_done = '0;
    endtask

    task automatic trial(input logic [7:0] k, output int vc);
        kq[0] = k; req_valid = 4'b0001;
        run_cycle();
        vc = gs[0] ? int'(gv[0]) : -1;
        req_valid = '0;
        release_all();
    endtask

    task automatic seeded_run(input logic [LW-1:0] s);
        int vc;
        seed_load = 1; seed_val = s;
        release_all();
        seed_load = 0;
        for (int t = 0; t < 24; t++) begin
            trial(KA, vc);
            seqb[t] = vc;
        end
    endtask

    initial begin
        int vc, c0, c1, w0, w2, pend_age [NREQ];
        int hist [NVC];
        logic [7:0] keys [6];
        bit same;
        void'($urandom(32'd20517));
        keys = '{KA, KS, KW, KZ, KV3, KS1};
        for (int e = 0; e < 256; e++) bt[e] = '0;
        for (int i = 0; i < NREQ; i++) begin kq[i] = '0; pend_age[i] = 0; end
        own = '0;
        rst_n = 0; seed_load = 0; seed_val = '0; tbl_we = 0;
        tbl_prev = '0; tbl_flow = '0; tbl_next = '0; tbl_nflow = '0; tbl_wts = '0;
        req_valid = '0; req_prev = '0; req_flow = '0; req_next = '0; req_nflow = '0;
        tail_done = '0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1: idle, then a request on an unwritten entry
        run_cycle();
        chk(gs == '0, "R1 idle grant after reset", int'(gs), 0);
        kq[0] = KA; req_valid = 4'b0001;
        run_cycle();
        chk(gs == '0, "R1 empty table", int'(gs), 0);
        req_valid = '0;

        wr(KA, {3'd1, 3'd1, 3'd1, 3'd1});
        wr(KS, 12'(5) << 6);
        wr(KW, 12'(3) | (12'(1) << 3));
        wr(KV3, 12'(1) << 9);
        wr(KS1, 12'(1) << 3);

        // R11 / R4: static entry, same-cycle grant
        kq[1] = KS; req_valid = 4'b0010;
        run_cycle();
        chk(gs == 4'b0010, "R11 same-cycle grant", int'(gs), 2);
        chk(gv[1] == 2'd2, "R4 static channel", int'(gv[1]), 2);
        req_valid = '0;

        // R3: wait while held, R6: release seen one cycle later
        kq[3] = KS; req_valid = 4'b1000;
        for (int t = 0; t < 3; t++) begin
            run_cycle();
            chk(gs == '0, "R3 wait on held channel", int'(gs), 0);
        end
        tail_done = 4'b0100;
        run_cycle();
        chk(gs == '0, "R6 no grant in release cycle", int'(gs), 0);
        tail_done = '0;
        run_cycle();
        chk(gs == 4'b1000 && gv[3] == 2'd2, "R6 grant after release", int'(gv[3]), 2);
        req_valid = '0;
        release_all();

        // R2: all-zero entry never granted
        kq[0] = KZ; req_valid = 4'b0001;
        for (int t = 0; t < 3; t++) begin
            run_cycle();
            chk(gs == '0, "R2 zero entry", int'(gs), 0);
        end
        req_valid = '0;

        // R6: tail on a free channel in its claim cycle is ignored
        kq[0] = KV3; req_valid = 4'b0001; tail_done = 4'b1000;
        run_cycle();
        chk(gs == 4'b0001 && gv[0] == 2'd3, "R6 claim with tail", int'(gv[0]), 3);
        tail_done = '0; kq[1] = KV3; req_valid = 4'b0010;
        run_cycle();
        chk(gs == '0, "R6 channel stayed held", int'(gs), 0);
        req_valid = '0;
        release_all();

        // R10: write and request in the same cycle
        kq[0] = KW; req_valid = 4'b0001;
        tbl_we = 1; tbl_prev = KW[7:6]; tbl_flow = KW[5:4];
        tbl_next = KW[3:2]; tbl_nflow = KW[1:0]; tbl_wts = 12'(1) << 9;
        run_cycle();
        tbl_we = 0;
        chk(gs[0] && gv[0] < 2'd2, "R10 old contents used", int'(gv[0]), 0);
        bt[KW] = 12'(1) << 9;
        req_valid = '0;
        release_all();
        trial(KW, vc);
        chk(vc == 3, "R10 new contents used", vc, 3);
        wr(KW, 12'(3) | (12'(1) << 3));

        // R7: weighted draw 3:1
        c0 = 0; c1 = 0;
        for (int t = 0; t < 400; t++) begin
            trial(KW, vc);
            if (vc == 0) c0++;
            else if (vc == 1) c1++;
        end
        chk(c0 + c1 == 400, "R7 only weighted channels", c0 + c1, 400);
        chk(c0 >= 240 && c0 <= 360, "R7 weight 3 share of 400", c0, 300);
        // R7: equal weights
        for (int v = 0; v < NVC; v++) hist[v] = 0;
        for (int t = 0; t < 400; t++) begin
            trial(KA, vc);
            if (vc >= 0) hist[vc]++;
        end
        for (int v = 0; v < NVC; v++)
            chk(hist[v] >= 50, "R7 equal weight coverage", hist[v], 100);

        // R8: two requesters on one channel
        w0 = 0; w2 = 0;
        for (int t = 0; t < 300; t++) begin
            kq[0] = KS1; kq[2] = KS1; req_valid = 4'b0101;
            run_cycle();
            chk($countones(gs) == 1 && gv[gs[0] ? 0 : 2] == 2'd1,
                "R5 single winner", $countones(gs), 1);
            if (gs[0]) w0++;
            if (gs[2]) w2++;
            req_valid = '0;
            release_all();
        end
        chk(w0 >= 75, "R8 requester 0 share", w0, 150);
        chk(w2 >= 75, "R8 requester 2 share", w2, 150);

        // R9: reproducible sequences; zero seed equals seed 1
        seeded_run(32'h1357_9BDF);
        for (int t = 0; t < 24; t++) seqa[t] = seqb[t];
        seeded_run(32'h1357_9BDF);
        same = 1;
        for (int t = 0; t < 24; t++) if (seqa[t] != seqb[t]) same = 0;
        chk(same, "R9 same seed same grants", int'(same), 1);
        seeded_run(32'h0000_0001);
        for (int t = 0; t < 24; t++) seqa[t] = seqb[t];
        seeded_run(32'h0000_0000);
        same = 1;
        for (int t = 0; t < 24; t++) if (seqa[t] != seqb[t]) same = 0;
        chk(same, "R9 zero seed acts as 1", int'(same), 1);

        // random phase: overlapping requests and releases
        for (int c = 0; c < 3000; c++) begin
            for (int i = 0; i < NREQ; i++) begin
                if (req_valid[i] && pend_age[i] > 20) req_valid[i] = 1'b0;
                if (!req_valid[i] && ($urandom % 4) == 0) begin
                    kq[i] = keys[$urandom % 6];
                    req_valid[i] = 1'b1;
                    pend_age[i] = 0;
                end
            end
            tail_done = own & NVC'($urandom);
            run_cycle();
            for (int i = 0; i < NREQ; i++) begin
                if (gs[i]) req_valid[i] = 1'b0;
                else if (req_valid[i]) pend_age[i]++;
            end
        end
        req_valid = '0;
        tail_done = '0;
        release_all();

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errs++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
            $finish;
        end
    end

endmodule